// File: doc/BRIEF.md
# Latest-Writer Tracking Matrix

This block keeps track of which functional unit will deliver the newest pending value of each architectural register. It is a bit matrix with one row per functional unit (FU) and one column per register. In each column at most one bit is set. A set bit names the producer that a later reader must wait on. The matrix takes the place of a destination-tag CAM in a reorder buffer: each column acts as a one-hot tag, and a new writer to a register simply overwrites that register's column.

The issue stage presents the issuing FU, an optional destination register and two source registers. In the same cycle, and with no register on the path, the block returns for each source a one-hot producer vector and a hit flag. When the hit flag is low, the operand is read straight from the register file. When an FU completes, its index is presented on the completion port, and every bit in that FU's row is dropped. The issue and completion inputs are plain control pins. They have no back-pressure: the matrix accepts one issue and one completion in every cycle, so no ready signal exists and a valid input is always consumed at the next rising edge.

Top module: `lwt_matrix`

## Requirements
- R1: No register column ever holds more than one set bit, so the producer vector for every lookup is either all zero or has exactly one bit set.
- R2: An issue with `iss_valid` and `iss_dst_en` high clears the destination column and, at the next rising edge, sets the single bit in row `iss_fu` of that column.
- R3: For each source, the producer vector bit at position k (bit 0 = FU 0) is set, with the hit flag high, exactly when FU k is the latest pending writer of that register.
- R4: When a source register's column is empty, the hit flag is low and the producer vector is all zero.
- R5: Lookups use the column state from before the current issue's own update, so an instruction that reads and writes the same register sees the previous writer and not itself.
- R6: A completion with `done_valid` high clears every bit in row `done_fu` at the next rising edge.
- R7: A completion from an FU that has already been superseded in a column leaves that column's newer writer unchanged.
- R8: When an issue and a completion hit the same column in one cycle, the issue wins and the newly set bit survives, even when the completing FU is the issuing FU.
- R9: A synchronous active-high `rst` clears the whole matrix at the next rising edge.
- R10: With `iss_valid` low, or with `iss_dst_en` low, an issue changes no column.
- R11: The lookup is combinational: a write that issues at one edge is visible to a source lookup in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_fu | input | FU_W | Index of the issuing FU |
| iss_dst_en | input | 1 | The issuing instruction writes a destination |
| iss_dst | input | REG_W | Destination register index |
| iss_src_a | input | REG_W | First source register index |
| iss_src_b | input | REG_W | Second source register index |
| done_valid | input | 1 | An FU completes this cycle |
| done_fu | input | FU_W | Index of the completing FU |
| src_a_prod | output | NUM_FU | One-hot producer vector for the first source |
| src_a_hit | output | 1 | First source has a pending producer |
| src_b_prod | output | NUM_FU | One-hot producer vector for the second source |
| src_b_hit | output | 1 | Second source has a pending producer |

## Verification
The bench builds the matrix with 4 FUs and 8 registers. With so few columns, random traffic runs into overwrites, superseded completions and same-cycle issue/completion collisions within a few cycles, far more often than the 8-by-32 default would. These widths keep the FU and register index fields at non-trivial widths of 2 and 3 bits. The bench also sweeps every column through the lookup port, so each cell of the matrix is observed at the pins.

// File: rtl/lwt_pkg.sv
package lwt_pkg;

  localparam int DEF_NUM_FU  = 8;
  localparam int DEF_NUM_REG = 32;

  // Next-state choice for one register column
  typedef enum logic [1:0] {
    COL_HOLD  = 2'd0,
    COL_SET   = 2'd1,
    COL_DROP  = 2'd2,
    COL_CLEAR = 2'd3
  } col_act_e;

endpackage

// File: rtl/lwt_column.sv
module lwt_column
  import lwt_pkg::*;
#(
  parameter int NUM_FU  = DEF_NUM_FU,
  parameter int COL_IDX = 0,
  parameter int FU_W    = 3,
  parameter int REG_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic              iss_dst_en,
  input  logic [REG_W-1:0]  iss_dst,
  input  logic [FU_W-1:0]   iss_fu,
  input  logic              done_valid,
  input  logic [FU_W-1:0]   done_fu,
  output logic [NUM_FU-1:0] col_q
);

  logic               targeted;
  col_act_e           act;
  logic [NUM_FU-1:0]  col_d;

  assign targeted = iss_valid && iss_dst_en && (iss_dst == REG_W'(COL_IDX));

  // Priority: reset, then a new writer, then a completion
  always_comb begin
    if (rst)             act = COL_CLEAR;
    else if (targeted)   act = COL_SET;
    else if (done_valid) act = COL_DROP;
    else                 act = COL_HOLD;
  end

  always_comb begin
    col_d = col_q;
    unique case (act)
      COL_CLEAR: col_d = '0;
      COL_SET: begin
        col_d = '0;
        if (int'(iss_fu) < NUM_FU) col_d[iss_fu] = 1'b1;
      end
      COL_DROP: begin
        if (int'(done_fu) < NUM_FU) col_d[done_fu] = 1'b0;
      end
      default: col_d = col_q;
    endcase
  end

  always_ff @(posedge clk) begin
    col_q <= col_d;
  end

  p_col_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_q));

  p_set_owner_r2: assert property (@(posedge clk) disable iff (rst)
    targeted |=> (col_q[$past(iss_fu)] && $onehot(col_q)));

  p_row_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !targeted) |=> !col_q[$past(done_fu)]);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!done_valid && !targeted) |=> $stable(col_q));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (col_q == '0));

endmodule

// File: rtl/lwt_lookup.sv
module lwt_lookup #(
  parameter int NUM_FU  = 8,
  parameter int NUM_REG = 32,
  parameter int REG_W   = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_REG-1:0][NUM_FU-1:0]  mat,
  input  logic [REG_W-1:0]                src,
  output logic [NUM_FU-1:0]               prod,
  output logic                            hit
);

  always_comb begin
    prod = '0;
    if (int'(src) < NUM_REG) prod = mat[src];
  end

  assign hit = |prod;

  p_lookup_single_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(prod));

endmodule

// File: rtl/lwt_matrix.sv
module lwt_matrix
  import lwt_pkg::*;
#(
  parameter int NUM_FU  = DEF_NUM_FU,
  parameter int NUM_REG = DEF_NUM_REG,
  localparam int FU_W   = (NUM_FU  > 1) ? $clog2(NUM_FU)  : 1,
  localparam int REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [FU_W-1:0]   iss_fu,
  input  logic              iss_dst_en,
  input  logic [REG_W-1:0]  iss_dst,
  input  logic [REG_W-1:0]  iss_src_a,
  input  logic [REG_W-1:0]  iss_src_b,
  input  logic              done_valid,
  input  logic [FU_W-1:0]   done_fu,
  output logic [NUM_FU-1:0] src_a_prod,
  output logic              src_a_hit,
  output logic [NUM_FU-1:0] src_b_prod,
  output logic              src_b_hit
);

  localparam int NUM_SRC = 2;

  logic [NUM_REG-1:0][NUM_FU-1:0] mat;
  logic [NUM_SRC-1:0][REG_W-1:0]  src_idx;
  logic [NUM_SRC-1:0][NUM_FU-1:0] src_prod;
  logic [NUM_SRC-1:0]             src_hit;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_col
    lwt_column #(
      .NUM_FU (NUM_FU),
      .COL_IDX(g),
      .FU_W   (FU_W),
      .REG_W  (REG_W)
    ) u_col (
      .clk       (clk),
      .rst       (rst),
      .iss_valid (iss_valid),
      .iss_dst_en(iss_dst_en),
      .iss_dst   (iss_dst),
      .iss_fu    (iss_fu),
      .done_valid(done_valid),
      .done_fu   (done_fu),
      .col_q     (mat[g])
    );
  end

  assign src_idx[0] = iss_src_a;
  assign src_idx[1] = iss_src_b;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    lwt_lookup #(
      .NUM_FU (NUM_FU),
      .NUM_REG(NUM_REG),
      .REG_W  (REG_W)
    ) u_look (
      .clk (clk),
      .rst (rst),
      .mat (mat),
      .src (src_idx[s]),
      .prod(src_prod[s]),
      .hit (src_hit[s])
    );
  end

  assign src_a_prod = src_prod[0];
  assign src_a_hit  = src_hit[0];
  assign src_b_prod = src_prod[1];
  assign src_b_hit  = src_hit[1];

  // A write issued at one edge is seen by a lookup of that register next cycle
  p_next_cycle_visible_r11: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_dst_en) ##1 (iss_src_a == $past(iss_dst))
      |-> (src_a_hit && src_a_prod[$past(iss_fu)]));

  // Issue beats a same-cycle completion by the same FU
  p_issue_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_dst_en && done_valid && (done_fu == iss_fu))
      ##1 (iss_src_b == $past(iss_dst)) |-> src_b_hit);

endmodule

// File: tb/lwt_matrix_test.sv
`timescale 1ns/1ps
module lwt_matrix_test;

  localparam int NF = 4;
  localparam int NR = 8;
  localparam int FW = 2;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          iss_valid, iss_dst_en, done_valid;
  logic [FW-1:0] iss_fu, done_fu;
  logic [RW-1:0] iss_dst, iss_src_a, iss_src_b;
  logic [NF-1:0] src_a_prod, src_b_prod;
  logic          src_a_hit, src_b_hit;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int lw [NR];

  always #2 clk = ~clk;

  lwt_matrix #(.NUM_FU(NF), .NUM_REG(NR)) uut (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_fu(iss_fu), .iss_dst_en(iss_dst_en),
    .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .done_valid(done_valid), .done_fu(done_fu),
    .src_a_prod(src_a_prod), .src_a_hit(src_a_hit),
    .src_b_prod(src_b_prod), .src_b_hit(src_b_hit)
  );

  function automatic logic [NF-1:0] exp_vec(int w);
    return (w >= 0) ? (NF'(1) << w) : '0;
  endfunction

  task automatic check_src(string tag, string which, logic [NF-1:0] prod,
                           logic hit, int w);
    checks++;
    if (prod !== exp_vec(w) || hit !== (w >= 0)) begin
      errors++;
      $display("FAIL %s src %s: prod=%b hit=%b expected prod=%b hit=%b",
               tag, which, prod, hit, exp_vec(w), (w >= 0));
    end
    checks++;
    if ($countones(prod) > 1) begin
      errors++;
      $display("FAIL R1 src %s: prod=%b expected at most one bit", which, prod);
    end
  endtask

  task automatic set_in(bit iv, int fu, bit de, int dst, int sa, int sb,
                        bit dv, int dfu);
    iss_valid = iv; iss_fu = FW'(fu); iss_dst_en = de; iss_dst = RW'(dst);
    iss_src_a = RW'(sa); iss_src_b = RW'(sb);
    done_valid = dv; done_fu = FW'(dfu);
  endtask

  // Inputs are set after a falling edge; lookup checked before the rising edge
  task automatic cyc(string tag);
    #1;
    if (!rst) begin
      check_src(tag, "a", src_a_prod, src_a_hit, lw[int'(iss_src_a)]);
      check_src(tag, "b", src_b_prod, src_b_hit, lw[int'(iss_src_b)]);
    end
    @(posedge clk);
    if (rst) begin
      for (int r = 0; r < NR; r++) lw[r] = -1;
    end else begin
      if (done_valid)
        for (int r = 0; r < NR; r++) if (lw[r] == int'(done_fu)) lw[r] = -1;
      if (iss_valid && iss_dst_en) lw[int'(iss_dst)] = int'(iss_fu);
    end
    @(negedge clk);
  endtask

  task automatic sweep(string tag);
    for (int r = 0; r < NR; r++) begin
      set_in(0, 0, 0, 0, r, NR - 1 - r, 0, 0);
      cyc(tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) lw[r] = -1;
    rst = 1'b1;
    set_in(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    repeat (3) cyc("R9");
    rst = 1'b0;
    sweep("R9");                             // R9 / R4: empty after reset

    set_in(1, 0, 1, 1, 2, 3, 0, 0); cyc("R2");  // mul-0 writes r1
    set_in(1, 3, 1, 1, 1, 2, 0, 0); cyc("R3");  // add-3 writes r1, reads r1 -> fu0
    set_in(0, 0, 0, 0, 1, 1, 0, 0); cyc("R11"); // r1 now points to fu3
    set_in(1, 2, 1, 1, 1, 5, 0, 0); cyc("R5");  // reads own dst: sees fu3
    set_in(0, 0, 0, 0, 1, 4, 1, 0); cyc("R7");  // fu0 completes, superseded
    set_in(0, 0, 0, 0, 1, 0, 0, 0); cyc("R7");  // r1 still fu2
    set_in(1, 2, 1, 6, 1, 6, 0, 0); cyc("R2");  // fu2 also owns r6
    set_in(0, 0, 0, 0, 1, 6, 1, 2); cyc("R6");  // fu2 completes
    set_in(0, 0, 0, 0, 1, 6, 0, 0); cyc("R6");  // both empty
    set_in(1, 1, 1, 4, 0, 0, 0, 0); cyc("R2");
    set_in(1, 1, 1, 4, 4, 4, 1, 1); cyc("R8");  // same fu issues and completes
    set_in(0, 0, 0, 0, 4, 4, 0, 0); cyc("R8");  // new bit survived
    set_in(0, 2, 1, 4, 4, 3, 0, 0); cyc("R10"); // valid low
    set_in(1, 2, 0, 4, 4, 3, 0, 0); cyc("R10"); // dst disabled
    set_in(0, 0, 0, 0, 4, 3, 0, 0); cyc("R10"); // still fu1
    sweep("R3");

    for (int i = 0; i < 3000; i++) begin
      set_in($urandom_range(0, 1), $urandom_range(0, NF - 1),
             $urandom_range(0, 1), $urandom_range(0, NR - 1),
             $urandom_range(0, NR - 1), $urandom_range(0, NR - 1),
             ($urandom_range(0, 3) == 0), $urandom_range(0, NF - 1));
      cyc("R3");
    end
    sweep("R1");

    rst = 1'b1;
    set_in(1, 1, 1, 2, 0, 0, 0, 0);
    cyc("R9");
    rst = 1'b0;
    sweep("R9");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule